// File: doc/BRIEF.md
# Rectangular Pixel Transfer Engine

This block moves rectangles of 16-bit pixels between a 32-bit word stream and an internal pixel memory, in either direction. A start pulse supplies a position word, a size word and a direction flag. The engine then walks the rectangle row by row. Every stream word carries two pixels. A write transfer unpacks incoming words into memory. A read transfer packs memory pixels into outgoing words.

The walk state is the current row, the column offset within that row and the rows still to go. This state survives any pause in the stream, so a host can deliver one transfer as many separate bursts of any length. Each burst continues at the exact column where the previous one stopped. Row addresses wrap at the bottom of the array and column addresses wrap at its right edge.

The array is `2**COL_BITS` columns by `2**ROW_BITS` rows. With `COL_BITS=10` and `ROW_BITS=9` it is the full 1024 by 512 array. The defaults are small so that the design elaborates quickly. The memory is a single-port synchronous RAM that can be inferred as block RAM.

Top module: `vram_rect_mover`

## Requirements
- R1: Decoding at start. X is `xfer_pos[COL_BITS-1:0]` and Y is `xfer_pos[16+ROW_BITS-1:16]`. Width is `xfer_size[15:0]` and height is `xfer_size[31:16]`. All other bits are ignored.
- R2: The pixel at column offset `k` of the current row is stored at address `Y*2**COL_BITS + ((X+k) mod 2**COL_BITS)`.
- R3: Pixel order within a word: the low 16 bits go to, or come from, the earlier pixel of the walk, and the high 16 bits the next one.
- R4: When the offset reaches the width, the offset returns to 0, Y becomes `(Y+1) mod 2**ROW_BITS` and the remaining height drops by one.
- R5: `busy` rises on the cycle after a start whose width and height are both nonzero. It falls once the last pixel of the rectangle has been walked. No word is accepted on the write port and no extra word appears on the read port after that point.
- R6: A pause of any length in the stream keeps the current row and offset, and the transfer resumes there.
- R7: A start with zero width or zero height leaves `busy` and `wr_ready` low and produces no read word.
- R8: `img_ready` is 0 after reset. It is 1 from the cycle after a read start and 0 from the cycle after a write start.
- R9: A start while a transfer is unfinished replaces all walk parameters. Pixels already written stay, and the new transfer begins at its own origin with offset 0.
- R10: When the pixel count is odd, the high half of the final write word is discarded and memory is left unchanged. On a read, the high half of the final word is 0.
- R11: After reset, `busy`, `img_ready`, `wr_ready` and `rd_valid` are all 0.
- R12: While `rd_valid` is high and `rd_ready` is low, `rd_data` and `rd_valid` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| xfer_start | input | 1 | One-cycle pulse that begins a transfer |
| xfer_pos | input | 32 | Position word (X, Y) |
| xfer_size | input | 32 | Size word (width, height) |
| xfer_read | input | 1 | 1 = memory to stream, 0 = stream to memory |
| wr_data | input | 32 | Incoming word, two pixels |
| wr_valid | input | 1 | Incoming word present |
| wr_ready | output | 1 | Engine accepts the incoming word |
| rd_data | output | 32 | Outgoing word, two pixels |
| rd_valid | output | 1 | Outgoing word present |
| rd_ready | input | 1 | Host takes the outgoing word |
| busy | output | 1 | Pixels of the rectangle remain to be walked |
| img_ready | output | 1 | A read transfer was the last one started |

## Verification
Several properties are checked on every cycle:
- the read word stays stable under backpressure;
- the `img_ready` flag follows the direction of each start;
- a zero-size start leaves the block idle with no read data;
- a nonzero start raises `busy`;
- the write port never offers `wr_ready` while idle.

Other behaviours can only be shown by the bench's scenarios, since they depend on what ends up in memory. These are pixel placement, low-half-first packing, row and column wrap, resumption across pauses, replacement of an unfinished transfer and the discarded half of an odd final word. The bench shows them by reading rectangles back and comparing them against an independent model of the walk.

// File: rtl/vrm_pkg.sv
package vrm_pkg;
  localparam int WORD_W = 32;
  localparam int PIX_W  = 16;
  localparam int DIM_W  = 16;
  localparam int Y_LSB  = 16;

  typedef logic [PIX_W-1:0]  pix_t;
  typedef logic [WORD_W-1:0] word_t;
  typedef logic [DIM_W-1:0]  dim_t;

  typedef enum logic [1:0] {
    RS_LO,      // ready to fetch the low pixel of a word
    RS_HI,      // low pixel in flight, fetch the high pixel
    RS_PAIR,    // both pixels fetched, pack a full word
    RS_SINGLE   // walk ended after one pixel, pack with zero high half
  } rd_state_e;
endpackage

// File: rtl/vrm_cursor.sv
module vrm_cursor
  import vrm_pkg::*;
#(
  parameter  int COL_BITS = 6,
  parameter  int ROW_BITS = 5,
  localparam int ADDR_W   = COL_BITS + ROW_BITS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  word_t             pos_word,
  input  word_t             size_word,
  input  logic              step,
  output logic              active,
  output logic              last,
  output logic [ADDR_W-1:0] addr
);
  logic [COL_BITS-1:0] x0_q;
  logic [ROW_BITS-1:0] y_q;
  dim_t                width_q;
  dim_t                off_q;
  dim_t                rows_q;
  logic                row_end;
  logic [COL_BITS-1:0] col;

  assign row_end = ({1'b0, off_q} + (DIM_W+1)'(1)) == {1'b0, width_q};
  assign active  = (width_q != '0) && (rows_q != '0);
  assign last    = active && row_end && (rows_q == dim_t'(1));
  assign col     = x0_q + off_q[COL_BITS-1:0];
  assign addr    = {y_q, col};

  always_ff @(posedge clk) begin
    if (rst) begin
      x0_q    <= '0;
      y_q     <= '0;
      width_q <= '0;
      off_q   <= '0;
      rows_q  <= '0;
    end else if (load) begin
      x0_q    <= pos_word[COL_BITS-1:0];
      y_q     <= pos_word[Y_LSB +: ROW_BITS];
      width_q <= size_word[DIM_W-1:0];
      rows_q  <= size_word[WORD_W-1:DIM_W];
      off_q   <= '0;
    end else if (step && active) begin
      if (row_end) begin
        off_q  <= '0;
        y_q    <= y_q + 1'b1;
        rows_q <= rows_q - 1'b1;
      end else begin
        off_q  <= off_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/vrm_pixel_ram.sv
module vrm_pixel_ram
  import vrm_pkg::*;
#(
  parameter  int ADDR_W = 11,
  localparam int DEPTH  = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              we,
  input  logic              re,
  input  logic [ADDR_W-1:0] addr,
  input  pix_t              wdata,
  output pix_t              rdata
);
  pix_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) rdata <= mem[addr];
  end
endmodule

// File: rtl/vrm_wr_unpack.sv
module vrm_wr_unpack
  import vrm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  flush,
  input  logic  enable,
  input  word_t in_data,
  input  logic  in_valid,
  output logic  in_ready,
  input  logic  take,
  input  logic  last,
  output pix_t  out_pix,
  output logic  out_valid
);
  word_t hold_q;
  logic  full_q;
  logic  phase_q;

  assign in_ready  = enable && !full_q;
  assign out_valid = full_q;
  assign out_pix   = phase_q ? hold_q[WORD_W-1:PIX_W] : hold_q[PIX_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hold_q  <= '0;
      full_q  <= 1'b0;
      phase_q <= 1'b0;
    end else if (in_valid && in_ready) begin
      hold_q  <= in_data;
      full_q  <= 1'b1;
      phase_q <= 1'b0;
    end else if (take && full_q) begin
      if (phase_q || last) begin
        full_q  <= 1'b0;
        phase_q <= 1'b0;
      end else begin
        phase_q <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/vrm_rd_pack.sv
module vrm_rd_pack
  import vrm_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  flush,
  input  logic  enable,
  input  logic  last,
  input  pix_t  ram_q,
  output logic  issue,
  output word_t out_data,
  output logic  out_valid,
  input  logic  out_ready
);
  rd_state_e st_q;
  pix_t      lo_q;
  word_t     data_q;
  logic      valid_q;

  assign issue     = ((st_q == RS_LO) && enable && !valid_q) || (st_q == RS_HI);
  assign out_data  = data_q;
  assign out_valid = valid_q;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      st_q    <= RS_LO;
      lo_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (valid_q && out_ready) valid_q <= 1'b0;
      unique case (st_q)
        RS_LO: begin
          if (enable && !valid_q) st_q <= last ? RS_SINGLE : RS_HI;
        end
        RS_HI: begin
          lo_q <= ram_q;
          st_q <= RS_PAIR;
        end
        RS_PAIR: begin
          data_q  <= {ram_q, lo_q};
          valid_q <= 1'b1;
          st_q    <= RS_LO;
        end
        RS_SINGLE: begin
          data_q  <= {{PIX_W{1'b0}}, ram_q};
          valid_q <= 1'b1;
          st_q    <= RS_LO;
        end
        default: st_q <= RS_LO;
      endcase
    end
  end
endmodule

// File: rtl/vram_rect_mover.sv
module vram_rect_mover
  import vrm_pkg::*;
#(
  parameter  int COL_BITS = 6,
  parameter  int ROW_BITS = 5,
  localparam int ADDR_W   = COL_BITS + ROW_BITS
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        xfer_start,
  input  logic [31:0] xfer_pos,
  input  logic [31:0] xfer_size,
  input  logic        xfer_read,
  input  logic [31:0] wr_data,
  input  logic        wr_valid,
  output logic        wr_ready,
  output logic [31:0] rd_data,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic        busy,
  output logic        img_ready
);
  logic              dir_rd_q;
  logic              img_q;
  logic              cur_active;
  logic              cur_last;
  logic [ADDR_W-1:0] cur_addr;
  logic              cur_step;
  pix_t              wr_pix;
  logic              wr_pix_valid;
  logic              wr_take;
  logic              rd_issue;
  pix_t              ram_rdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      dir_rd_q <= 1'b0;
      img_q    <= 1'b0;
    end else if (xfer_start) begin
      dir_rd_q <= xfer_read;
      img_q    <= xfer_read;
    end
  end

  assign wr_take   = wr_pix_valid && cur_active && !dir_rd_q;
  assign cur_step  = dir_rd_q ? rd_issue : wr_take;
  assign busy      = cur_active;
  assign img_ready = img_q;

  vrm_cursor #(
    .COL_BITS (COL_BITS),
    .ROW_BITS (ROW_BITS)
  ) i_cursor (
    .clk       (clk),
    .rst       (rst),
    .load      (xfer_start),
    .pos_word  (xfer_pos),
    .size_word (xfer_size),
    .step      (cur_step),
    .active    (cur_active),
    .last      (cur_last),
    .addr      (cur_addr)
  );

  vrm_pixel_ram #(
    .ADDR_W (ADDR_W)
  ) i_ram (
    .clk   (clk),
    .we    (wr_take),
    .re    (rd_issue),
    .addr  (cur_addr),
    .wdata (wr_pix),
    .rdata (ram_rdata)
  );

  vrm_wr_unpack i_wr (
    .clk       (clk),
    .rst       (rst),
    .flush     (xfer_start),
    .enable    (cur_active && !dir_rd_q),
    .in_data   (wr_data),
    .in_valid  (wr_valid),
    .in_ready  (wr_ready),
    .take      (wr_take),
    .last      (cur_last),
    .out_pix   (wr_pix),
    .out_valid (wr_pix_valid)
  );

  vrm_rd_pack i_rd (
    .clk       (clk),
    .rst       (rst),
    .flush     (xfer_start),
    .enable    (cur_active && dir_rd_q),
    .last      (cur_last),
    .ram_q     (ram_rdata),
    .issue     (rd_issue),
    .out_data  (rd_data),
    .out_valid (rd_valid),
    .out_ready (rd_ready)
  );
endmodule

// File: rtl/vrm_checker.sv
module vrm_checker (
  input logic        clk,
  input logic        rst,
  input logic        xfer_start,
  input logic [31:0] xfer_size,
  input logic        xfer_read,
  input logic        wr_ready,
  input logic [31:0] rd_data,
  input logic        rd_valid,
  input logic        rd_ready,
  input logic        busy,
  input logic        img_ready
);
  logic size_zero;
  assign size_zero = (xfer_size[15:0] == 16'd0) || (xfer_size[31:16] == 16'd0);

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (rst)
    rd_valid && !rd_ready && !xfer_start |=> rd_valid && $stable(rd_data)); // R12
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !wr_ready); // R5
  AST_START_BUSY: assert property (@(posedge clk) disable iff (rst)
    xfer_start && !size_zero |=> busy); // R5
  AST_IMG_SET: assert property (@(posedge clk) disable iff (rst)
    xfer_start && xfer_read |=> img_ready); // R8
  AST_IMG_CLR: assert property (@(posedge clk) disable iff (rst)
    xfer_start && !xfer_read |=> !img_ready); // R8
  AST_WR_NOT_IMG: assert property (@(posedge clk) disable iff (rst)
    wr_ready |-> !img_ready); // R8
  AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (rst)
    xfer_start && size_zero |=> !busy && !wr_ready); // R7
  AST_ZERO_NO_DATA: assert property (@(posedge clk) disable iff (rst)
    xfer_start && size_zero |=> !rd_valid); // R7
endmodule

bind vram_rect_mover vrm_checker i_chk (
  .clk        (clk),
  .rst        (rst),
  .xfer_start (xfer_start),
  .xfer_size  (xfer_size),
  .xfer_read  (xfer_read),
  .wr_ready   (wr_ready),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .rd_ready   (rd_ready),
  .busy       (busy),
  .img_ready  (img_ready)
);

// File: tb/test_vram_rect_mover.sv
module test_vram_rect_mover;
  localparam int COL_BITS = 6;
  localparam int ROW_BITS = 5;
  localparam int COLS = 1 << COL_BITS;
  localparam int ROWS = 1 << ROW_BITS;
  localparam int NPIX = COLS * ROWS;
  localparam int NVEC = 6;
  // {position word, size word, idle cycles between words}
  localparam logic [71:0] VEC [NVEC] = '{
    {32'h0000_0000, 32'h0020_0040, 8'd0},
    {32'h0003_0005, 32'h0004_0007, 8'd3},
    {32'h001E_003C, 32'h0005_0006, 8'd2},
    {32'h000C_000A, 32'h0003_0005, 8'd1},
    {32'h001F_0000, 32'h0002_0040, 8'd0},
    {32'hFFF4_FFE1, 32'h0002_0004, 8'd1}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        xfer_start = 1'b0;
  logic [31:0] xfer_pos = '0;
  logic [31:0] xfer_size = '0;
  logic        xfer_read = 1'b0;
  logic [31:0] wr_data = '0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [31:0] rd_data;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic        busy;
  logic        img_ready;

  int n_cmp = 0;
  int n_bad = 0;
  logic [15:0] mdl [NPIX];
  int m_x, m_y, m_off, m_w, m_h;

  always #10 clk = ~clk;

  vram_rect_mover #(.COL_BITS(COL_BITS), .ROW_BITS(ROW_BITS)) i_vram_rect_mover (
    .clk(clk), .rst(rst), .xfer_start(xfer_start), .xfer_pos(xfer_pos),
    .xfer_size(xfer_size), .xfer_read(xfer_read), .wr_data(wr_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .rd_data(rd_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .busy(busy), .img_ready(img_ready)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Bench model of the walk, built from R1, R2, R4
  task automatic model_start(input logic [31:0] pos, input logic [31:0] size);
    m_x = int'(pos) & (COLS - 1);
    m_y = int'(pos >> 16) & (ROWS - 1);
    m_w = int'(size[15:0]);
    m_h = int'(size[31:16]);
    m_off = 0;
  endtask

  function automatic bit model_live();
    return (m_w != 0) && (m_h != 0);
  endfunction

  function automatic int model_addr();
    return m_y * COLS + ((m_x + m_off) % COLS);
  endfunction

  task automatic model_adv();
    if (m_off + 1 == m_w) begin
      m_off = 0;
      m_y = (m_y + 1) % ROWS;
      m_h--;
    end else begin
      m_off++;
    end
  endtask

  task automatic start_xfer(input logic [31:0] pos, input logic [31:0] size, input logic rd);
    xfer_pos = pos; xfer_size = size; xfer_read = rd; xfer_start = 1'b1;
    @(negedge clk);
    xfer_start = 1'b0;
    model_start(pos, size);
  endtask

  task automatic send_word(input logic [31:0] w);
    wr_data = w; wr_valid = 1'b1;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
    for (int h = 0; h < 2; h++) begin
      if (model_live()) begin
        mdl[model_addr()] = (h == 0) ? w[15:0] : w[31:16];
        model_adv();
      end
    end
  endtask

  task automatic recv_word(input int stall, input string tag);
    logic [31:0] held;
    logic [31:0] exp;
    rd_ready = 1'b0;
    while (!rd_valid) @(negedge clk);
    if (stall > 0) begin
      held = rd_data;
      repeat (stall) @(negedge clk);
      chk("R12", "word held under backpressure", {rd_valid, rd_data[30:0]}, {1'b1, held[30:0]});
    end
    for (int h = 0; h < 2; h++) begin
      logic [15:0] p;
      p = 16'h0000;
      if (model_live()) begin
        p = mdl[model_addr()];
        model_adv();
      end
      if (h == 0) exp[15:0] = p; else exp[31:16] = p;
    end
    chk(tag, "read word", rd_data, exp);
    rd_ready = 1'b1;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic write_rect(input logic [31:0] pos, input logic [31:0] size, input int gap, input int seed);
    int n;
    int t;
    n = (int'(size[15:0]) * int'(size[31:16]) + 1) / 2;
    start_xfer(pos, size, 1'b0);
    chk("R8", "img_ready after write start", {31'd0, img_ready}, 32'd0);
    for (int i = 0; i < n; i++) begin
      send_word({16'(seed * 1024 + 2 * i + 1), 16'(seed * 1024 + 2 * i)});
      repeat (gap) @(negedge clk);
    end
    t = 0;
    while (busy && t < 6) begin @(negedge clk); t++; end
    chk("R5", "busy after last write word", {31'd0, busy}, 32'd0);
    chk("R5", "wr_ready after write end", {31'd0, wr_ready}, 32'd0);
  endtask

  task automatic read_rect(input logic [31:0] pos, input logic [31:0] size, input int gap, input string tag);
    int n;
    n = (int'(size[15:0]) * int'(size[31:16]) + 1) / 2;
    start_xfer(pos, size, 1'b1);
    chk("R8", "img_ready after read start", {31'd0, img_ready}, 32'd1);
    for (int i = 0; i < n; i++) recv_word(gap, tag);
    repeat (6) @(negedge clk);
    chk("R5", "busy after last read word", {31'd0, busy}, 32'd0);
    chk("R5", "no extra read word", {31'd0, rd_valid}, 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    chk("R11", "busy after reset", {31'd0, busy}, 32'd0);
    chk("R11", "img_ready after reset", {31'd0, img_ready}, 32'd0);
    chk("R11", "wr_ready after reset", {31'd0, wr_ready}, 32'd0);
    chk("R11", "rd_valid after reset", {31'd0, rd_valid}, 32'd0);

    // vector table: write then read back each rectangle (R1 R2 R3 R4 R6 R12)
    for (int v = 0; v < NVEC; v++) begin
      write_rect(VEC[v][71:40], VEC[v][39:8], int'(VEC[v][7:0]), v + 1);
      read_rect(VEC[v][71:40], VEC[v][39:8], int'(VEC[v][7:0]), "R1/R2/R3/R4");
    end

    // R10: odd pixel count, high half of final write word dropped
    start_xfer(32'h0014_0014, 32'h0001_0003, 1'b0);
    send_word(32'hA1A1_A0A0);
    send_word(32'hB1B1_B0B0);
    repeat (4) @(negedge clk);
    read_rect(32'h0014_0014, 32'h0001_0004, 0, "R10");
    read_rect(32'h0014_0014, 32'h0001_0003, 2, "R10");

    // R7: zero width, zero height
    start_xfer(32'h0000_0008, 32'h0004_0000, 1'b0);
    chk("R7", "busy on zero width", {31'd0, busy}, 32'd0);
    chk("R7", "wr_ready on zero width", {31'd0, wr_ready}, 32'd0);
    start_xfer(32'h0000_0008, 32'h0000_0004, 1'b0);
    chk("R7", "busy on zero height", {31'd0, busy}, 32'd0);
    start_xfer(32'h0000_0008, 32'h0000_0004, 1'b1);
    rd_ready = 1'b1;
    repeat (8) @(negedge clk);
    rd_ready = 1'b0;
    chk("R7", "no read word on zero size", {31'd0, rd_valid}, 32'd0);

    // R6: long pause mid-row keeps the position
    start_xfer(32'h0002_0002, 32'h0002_0005, 1'b0);
    send_word(32'h6001_6000);
    repeat (20) @(negedge clk);
    chk("R6", "busy held through pause", {31'd0, busy}, 32'd1);
    for (int i = 1; i < 5; i++) send_word({16'(16'h6000 + 2 * i + 1), 16'(16'h6000 + 2 * i)});
    repeat (4) @(negedge clk);
    read_rect(32'h0002_0002, 32'h0002_0005, 3, "R6");

    // R9: restart over an unfinished transfer
    start_xfer(32'h0005_0028, 32'h0002_0004, 1'b0);
    send_word(32'h9101_9100);
    repeat (5) @(negedge clk);
    chk("R9", "first transfer unfinished", {31'd0, busy}, 32'd1);
    start_xfer(32'h0006_0028, 32'h0001_0002, 1'b0);
    send_word(32'h9201_9200);
    repeat (4) @(negedge clk);
    chk("R9", "restarted transfer done", {31'd0, busy}, 32'd0);
    read_rect(32'h0005_0028, 32'h0002_0004, 0, "R9");

    summary();
    $finish;
  end
endmodule